// File: doc/BRIEF.md
# Register-Mapped Serial Port with Latched Interrupts

This block is a minimal asynchronous serial port that sits on an APB bus as a zero-wait-state slave. Software sees five word registers: a data port, a status word, a control word, an interrupt word and a bit-period divider. It reads the interrupt word for pending causes and writes the same word to clear them. Each direction buffers exactly one character. The transmitter holds one character while the shifter is busy, and the receiver holds the last completed character until software reads it. There is no FIFO and no flow-control wire: the only serial pins are one input line and one output line.

Characters use 8 data bits, no parity and one stop bit, with the least significant bit first and the line idling high. The divider gives the number of system clocks per bit. The receiver finds the start edge after a two-flop synchronizer, then samples each bit near its middle. Four interrupt causes are latched independently, each behind its own enable: transmit holding register drained, character received, transmit overrun and receive overrun. Two of them drive dedicated pins, and one more pin carries the OR of all four.

Top module: `serial_port_apb`

## Requirements
- R1: After reset the serial output is high, all interrupt outputs are low, and the status, control, interrupt and divider registers read 0. The ready output is 1 and the error output is 0 at all times.
- R2: Word 2 (byte offset 0x008) reads back bits [6:0] of the last written value with the upper bits as 0. Word 4 (0x010) reads back the written divider (16 bits). Any word index above 4 reads 0.
- R3: With control bit0 (transmit on) set and bit6 clear, a character written to word 0 (0x000) is sent as follows: a low start bit, the 8 data bits least significant first, then a high stop bit. Each bit lasts exactly divider clocks (a divider of 0 acts as 1). The start bit appears on the clock edge after the write's access edge.
- R4: Status bit0 (transmit full) sets on a data write while it is clear. It clears on the edge where the character moves into an idle, enabled shifter.
- R5: A data write while status bit0 is set sets status bit2 (transmit overrun) and is dropped. The character already held is the one sent.
- R6: While control bit0 is clear the serial output stays high and a held character stays held, with status bit0 remaining 1.
- R7: With control bit6 set, each transmitted bit lasts one clock, whatever the divider.
- R8: With control bit1 (receive on) set, a well-formed frame on the input sets status bit1 (receive full). A read of word 0 returns the character in bits [7:0] and clears status bit1.
- R9: A frame that completes while status bit1 is set, with no read of word 0 on the same edge, sets status bit3 (receive overrun) and is discarded. The held character is unchanged.
- R10: While control bit1 is clear, incoming frames are ignored and status bit1 stays 0.
- R11: Writing 1 to status bit2 or bit3 at word 1 (0x004) clears that overrun flag. Writing 0 leaves it unchanged.
- R12: The interrupt word (word 3, 0x00C) has four bits. Bit0 latches when a held character moves to the shifter and control bit2 is set. Bit1 latches when a character enters the receive holding register and control bit3 is set. Bit2 latches on a transmit overrun when control bit4 is set. Bit3 latches on a receive overrun when control bit5 is set. The transmit interrupt pin shows bit0, the receive interrupt pin shows bit1, and the combined pin is the OR of all four bits. An event whose enable is clear latches nothing.
- R13: Writing 1 to a bit of word 3 clears that latched interrupt. If the same bit's event occurs on the same edge as the clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | ADDR_W | APB byte address; bits above [1:0] select the word |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| tx_irq | output | 1 | Latched transmit-drained interrupt |
| rx_irq | output | 1 | Latched character-received interrupt |
| any_irq | output | 1 | OR of all four latched interrupts |

## Verification
A software clear of the receive interrupt can land on the same clock edge as a newly latched receive event. The design has to let the new event win on that edge. To provoke this, the bench first sends a frame and records the cycle at which the receive interrupt pin rises. It then repeats the identical frame from the same start cycle, with a clear write timed so its access edge lands one edge before that cycle, on it, and one edge after it. The pin must stay high in the first two runs and be low in the third. This shows set-over-clear priority is exact to the cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // word indices within the register window (byte offset = index * 4)
  localparam int WORD_DATA = 0;
  localparam int WORD_STAT = 1;
  localparam int WORD_CTRL = 2;
  localparam int WORD_INT  = 3;
  localparam int WORD_DIV  = 4;

  // status bit positions
  localparam int ST_TXFULL = 0;
  localparam int ST_RXFULL = 1;
  localparam int ST_TXOVR  = 2;
  localparam int ST_RXOVR  = 3;
  localparam int ST_W      = 4;

  // interrupt bit positions
  localparam int IRQ_TX    = 0;
  localparam int IRQ_RX    = 1;
  localparam int IRQ_TXOVR = 2;
  localparam int IRQ_RXOVR = 3;
  localparam int IRQ_N     = 4;

  // control word, packed msb first so that tx_on is bit 0 and tx_fast bit 6
  typedef struct packed {
    logic tx_fast;
    logic rxo_ie;
    logic txo_ie;
    logic rx_ie;
    logic tx_ie;
    logic rx_on;
    logic tx_on;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int DIV_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fast,
  input  logic [DIV_W-1:0]  div,
  input  logic              load_stb,
  input  logic [CHAR_W-1:0] load_char,
  output logic              full,
  output logic              drain,
  output logic              txd
);
  localparam int FRAME_BITS = CHAR_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [CHAR_W-1:0] hold_q;
  logic [CHAR_W:0]   shift_q;
  logic [CNT_W-1:0]  left_q;
  logic [DIV_W-1:0]  tick_q;
  logic [DIV_W-1:0]  bit_len_m1;
  logic              busy_q;
  logic              full_q;
  logic              line_q;
  logic              start;

  always_comb bit_len_m1 = (fast || div == '0) ? '0 : div - 1'b1;
  assign start = en && full_q && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      shift_q <= '0;
      left_q  <= '0;
      tick_q  <= '0;
      busy_q  <= 1'b0;
      full_q  <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      if (load_stb && !full_q) begin
        hold_q <= load_char;
        full_q <= 1'b1;
      end
      if (!en) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else if (start) begin
        full_q  <= 1'b0;
        busy_q  <= 1'b1;
        line_q  <= 1'b0;
        shift_q <= {1'b1, hold_q};
        left_q  <= CNT_W'(FRAME_BITS - 1);
        tick_q  <= bit_len_m1;
      end else if (busy_q) begin
        if (tick_q != '0) begin
          tick_q <= tick_q - 1'b1;
        end else if (left_q != '0) begin
          line_q  <= shift_q[0];
          shift_q <= shift_q >> 1;
          left_q  <= left_q - 1'b1;
          tick_q  <= bit_len_m1;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign full  = full_q;
  assign drain = start;
  assign txd   = line_q;

  assert_line_high_off_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> txd);
  assert_drain_empties_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> !full_q);
  assert_hold_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (load_stb && full_q) |=> $stable(hold_q));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              rxd,
  output logic              done,
  output logic [CHAR_W-1:0] char_out
);
  localparam int IDX_W = $clog2(CHAR_W);

  rx_state_e         state_q;
  logic              sync1_q, sync2_q, prev_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAR_W-1:0] shift_q;
  logic              done_q;
  logic [CHAR_W-1:0] char_q;
  logic [DIV_W-1:0]  bit_len_m1;
  logic [DIV_W-1:0]  half_m1;

  always_comb begin
    bit_len_m1 = (div == '0) ? '0 : div - 1'b1;
    half_m1    = ((div >> 1) == '0) ? '0 : (div >> 1) - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      done_q  <= 1'b0;
      if (!en) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: begin
            if (prev_q && !sync2_q) begin
              state_q <= RX_START;
              cnt_q   <= half_m1;
            end
          end
          RX_START: begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            else if (!sync2_q) begin
              state_q <= RX_DATA;
              cnt_q   <= bit_len_m1;
              idx_q   <= '0;
            end else state_q <= RX_IDLE;
          end
          RX_DATA: begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            else begin
              shift_q <= {sync2_q, shift_q[CHAR_W-1:1]};
              cnt_q   <= bit_len_m1;
              if (idx_q == IDX_W'(CHAR_W - 1)) state_q <= RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            else begin
              state_q <= RX_IDLE;
              if (sync2_q) begin
                done_q <= 1'b1;
                char_q <= shift_q;
              end
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done     = done_q;
  assign char_out = char_q;

  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> state_q == RX_IDLE);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/sp_irq.sv
module sp_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         any
);
  logic [N-1:0] pend_q, pend_d;
  logic         any_q;

  // an event on the same edge as its clear wins
  always_comb pend_d = (pend_q & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      any_q  <= |pend_d;
    end
  end

  assign pend = pend_q;
  assign any  = any_q;

  assert_set_wins_R13: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((pend_q & $past(set)) == $past(set)));
  assert_any_is_or_R12: assert property (@(posedge clk) disable iff (rst)
    any_q == (|pend_q));
endmodule

// File: rtl/serial_port_apb.sv
module serial_port_apb
  import sp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rxd,
  output logic              txd,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              any_irq
);
  localparam int WORD_W = ADDR_W - 2;

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              tx_ovr_q, rx_ovr_q, rx_full_q;
  logic [CHAR_W-1:0] rx_hold_q;

  logic [WORD_W-1:0] word;
  logic              wr_acc, rd_acc;
  logic              hit_data, hit_stat, hit_ctrl, hit_int, hit_div;
  logic              tx_wr, tx_full, tx_drain, tx_ovr_evt;
  logic              rx_done, rx_rd, rx_accept, rx_ovr_evt;
  logic [CHAR_W-1:0] rx_char;
  logic [IRQ_N-1:0]  irq_set, irq_clr, irq_pend;
  logic [ST_W-1:0]   stat;
  logic              unused_bits;

  assign word     = paddr[ADDR_W-1:2];
  assign wr_acc   = psel && penable && pwrite;
  assign rd_acc   = psel && penable && !pwrite;
  assign hit_data = word == WORD_W'(WORD_DATA);
  assign hit_stat = word == WORD_W'(WORD_STAT);
  assign hit_ctrl = word == WORD_W'(WORD_CTRL);
  assign hit_int  = word == WORD_W'(WORD_INT);
  assign hit_div  = word == WORD_W'(WORD_DIV);
  assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:DIV_W]};

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // transmit side
  assign tx_wr      = wr_acc && hit_data;
  assign tx_ovr_evt = tx_wr && tx_full;

  sp_tx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_q.tx_on),
    .fast      (ctrl_q.tx_fast),
    .div       (div_q),
    .load_stb  (tx_wr),
    .load_char (pwdata[CHAR_W-1:0]),
    .full      (tx_full),
    .drain     (tx_drain),
    .txd       (txd)
  );

  // receive side
  sp_rx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .en       (ctrl_q.rx_on),
    .div      (div_q),
    .rxd      (rxd),
    .done     (rx_done),
    .char_out (rx_char)
  );

  assign rx_rd      = rd_acc && hit_data;
  assign rx_accept  = rx_done && (!rx_full_q || rx_rd);
  assign rx_ovr_evt = rx_done && rx_full_q && !rx_rd;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      tx_ovr_q  <= 1'b0;
      rx_ovr_q  <= 1'b0;
      rx_full_q <= 1'b0;
      rx_hold_q <= '0;
    end else begin
      if (wr_acc && hit_ctrl) ctrl_q <= ctrl_t'(pwdata[CTRL_W-1:0]);
      if (wr_acc && hit_div)  div_q  <= pwdata[DIV_W-1:0];
      tx_ovr_q <= (tx_ovr_q && !(wr_acc && hit_stat && pwdata[ST_TXOVR])) || tx_ovr_evt;
      rx_ovr_q <= (rx_ovr_q && !(wr_acc && hit_stat && pwdata[ST_RXOVR])) || rx_ovr_evt;
      if (rx_accept) begin
        rx_hold_q <= rx_char;
        rx_full_q <= 1'b1;
      end else if (rx_rd) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  // interrupts
  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_TX]    = tx_drain   && ctrl_q.tx_ie;
    irq_set[IRQ_RX]    = rx_accept  && ctrl_q.rx_ie;
    irq_set[IRQ_TXOVR] = tx_ovr_evt && ctrl_q.txo_ie;
    irq_set[IRQ_RXOVR] = rx_ovr_evt && ctrl_q.rxo_ie;
    irq_clr            = (wr_acc && hit_int) ? pwdata[IRQ_N-1:0] : '0;
  end

  sp_irq #(.N(IRQ_N)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .set  (irq_set),
    .clr  (irq_clr),
    .pend (irq_pend),
    .any  (any_irq)
  );

  assign tx_irq = irq_pend[IRQ_TX];
  assign rx_irq = irq_pend[IRQ_RX];

  // read mux, valid during the access phase
  always_comb begin
    stat            = '0;
    stat[ST_TXFULL] = tx_full;
    stat[ST_RXFULL] = rx_full_q;
    stat[ST_TXOVR]  = tx_ovr_q;
    stat[ST_RXOVR]  = rx_ovr_q;
    prdata = '0;
    if (hit_data)      prdata = DATA_W'(rx_hold_q);
    else if (hit_stat) prdata = DATA_W'(stat);
    else if (hit_ctrl) prdata = DATA_W'(ctrl_q);
    else if (hit_int)  prdata = DATA_W'(irq_pend);
    else if (hit_div)  prdata = DATA_W'(div_q);
  end

  assert_tx_ovr_flag_R5: assert property (@(posedge clk) disable iff (rst)
    tx_ovr_evt |=> tx_ovr_q);
  assert_rx_ovr_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    rx_ovr_evt |=> (rx_ovr_q && $stable(rx_hold_q)));
  assert_read_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !rx_done) |=> !rx_full_q);
  assert_no_err_R1: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);
endmodule

// File: tb/serial_port_apb_bench.sv
module serial_port_apb_bench;
  localparam logic [11:0] A_DATA = 12'h000;
  localparam logic [11:0] A_STAT = 12'h004;
  localparam logic [11:0] A_CTRL = 12'h008;
  localparam logic [11:0] A_INT  = 12'h00C;
  localparam logic [11:0] A_DIV  = 12'h010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rxd = 1'b1;
  logic        txd, tx_irq, rx_irq, any_irq;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_port_apb u_serial_port_apb (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rxd(rxd), .txd(txd), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .any_irq(any_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_write_at(input logic [11:0] a, input logic [31:0] d, input int target);
    do @(negedge clk); while (cyc != target - 2);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(posedge clk);
    #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_read(a, d);
    check(req, d, exp);
  endtask

  // follows a write whose access edge has just passed; L clocks per bit
  task automatic watch_frame(input string req, input logic [7:0] b, input int L);
    int mism = 0;
    @(negedge clk);
    if (txd !== 1'b1) mism++;
    for (int i = 0; i < 10 * L; i++) begin
      logic expb;
      @(posedge clk);
      @(negedge clk);
      if (i / L == 0) expb = 1'b0;
      else if (i / L == 9) expb = 1'b1;
      else expb = b[i / L - 1];
      if (txd !== expb) mism++;
    end
    check(req, mism, 0);
  endtask

  task automatic rx_send(input logic [7:0] b, input int L);
    @(negedge clk);
    rxd = 1'b0;
    repeat (L) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxd = b[k];
      repeat (L) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (L) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic rx_send_at(input logic [7:0] b, input int L, input int s);
    do @(negedge clk); while (cyc != s);
    rx_send(b, L);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int dly, s;
    int divs_tx[5] = '{1, 2, 3, 5, 8};
    int divs_rx[3] = '{4, 7, 16};
    logic [7:0] pats[6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    logic [31:0] d;

    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 txd", txd, 1);
    check("R1 irqs", {tx_irq, rx_irq, any_irq}, 0);
    check("R1 pready/pslverr", {pready, pslverr}, 2'b10);
    rd_check("R1 status", A_STAT, 0);
    rd_check("R1 ctrl", A_CTRL, 0);
    rd_check("R1 int", A_INT, 0);
    rd_check("R1 div", A_DIV, 0);

    // R2 readback
    apb_write(A_CTRL, 32'hFFFF_FF80);
    rd_check("R2 ctrl upper ignored", A_CTRL, 0);
    apb_write(A_DIV, 32'h0000_1234);
    rd_check("R2 div", A_DIV, 32'h1234);
    rd_check("R2 unmapped", 12'h014, 0);
    rd_check("R2 unmapped high", 12'hFFC, 0);

    // R3 frame sweep over divider and patterns
    apb_write(A_CTRL, 32'h1);
    foreach (divs_tx[i]) begin
      apb_write(A_DIV, divs_tx[i]);
      foreach (pats[j]) begin
        apb_write(A_DATA, {24'h0, pats[j]});
        watch_frame($sformatf("R3 div=%0d byte=%02h", divs_tx[i], pats[j]), pats[j], divs_tx[i]);
      end
    end
    apb_write(A_DIV, 0);
    apb_write(A_DATA, 32'hC3);
    watch_frame("R3 div=0 acts as 1", 8'hC3, 1);

    // R7 fast mode, every byte
    apb_write(A_DIV, 50);
    apb_write(A_CTRL, 32'h41);
    for (int b = 0; b < 256; b++) begin
      apb_write(A_DATA, b);
      watch_frame($sformatf("R7 fast byte=%02h", b), 8'(b), 1);
    end

    // R6 and R5: transmitter off holds the character, overrun on second write
    apb_write(A_CTRL, 0);
    apb_write(A_DIV, 4);
    apb_write(A_DATA, 32'h33);
    rd_check("R4 full after write", A_STAT, 32'h1);
    dly = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) dly++;
    end
    check("R6 line high while off", dly, 0);
    rd_check("R6 char still held", A_STAT, 32'h1);
    apb_write(A_DATA, 32'h44);
    rd_check("R5 overrun flag", A_STAT, 32'h5);
    apb_write(A_CTRL, 32'h1);
    watch_frame("R5 first char sent", 8'h33, 4);
    rd_check("R4 full cleared", A_STAT, 32'h4);
    apb_write(A_STAT, 0);
    rd_check("R11 write 0 keeps", A_STAT, 32'h4);
    apb_write(A_STAT, 32'h4);
    rd_check("R11 write 1 clears", A_STAT, 0);

    // R8 receive sweep
    foreach (divs_rx[i]) begin
      apb_write(A_DIV, divs_rx[i]);
      apb_write(A_CTRL, 32'h2);
      foreach (pats[j]) begin
        rx_send(pats[j], divs_rx[i]);
        rd_check($sformatf("R8 full div=%0d", divs_rx[i]), A_STAT, 32'h2);
        rd_check($sformatf("R8 data div=%0d", divs_rx[i]), A_DATA, {24'h0, pats[j]});
        rd_check("R8 read empties", A_STAT, 0);
      end
    end
    apb_write(A_DIV, 4);
    for (int b = 0; b < 256; b++) begin
      rx_send(8'(b), 4);
      rd_check($sformatf("R8 byte=%02h", b), A_DATA, b);
    end

    // R9 receive overrun
    rx_send(8'h11, 4);
    rx_send(8'h22, 4);
    rd_check("R9 overrun flag", A_STAT, 32'hA);
    rd_check("R9 first kept", A_DATA, 32'h11);
    apb_write(A_STAT, 32'h8);
    rd_check("R11 rx overrun cleared", A_STAT, 0);

    // R10 receiver off
    apb_write(A_CTRL, 32'h1);
    rx_send(8'h77, 4);
    rd_check("R10 ignored", A_STAT, 0);

    // R12 interrupts
    apb_write(A_CTRL, 32'h1);
    apb_write(A_DATA, 32'h10);
    repeat (50) @(negedge clk);
    rd_check("R12 no latch when disabled", A_INT, 0);
    apb_write(A_CTRL, 32'h5);
    apb_write(A_DATA, 32'h20);
    repeat (50) @(negedge clk);
    check("R12 tx pins", {tx_irq, rx_irq, any_irq}, 3'b101);
    rd_check("R12 tx bit", A_INT, 32'h1);
    apb_write(A_INT, 32'h1);
    @(negedge clk);
    check("R13 tx clear", {tx_irq, any_irq}, 0);
    apb_write(A_CTRL, 32'h10);
    apb_write(A_DATA, 32'h01);
    apb_write(A_DATA, 32'h02);
    @(negedge clk);
    check("R12 tx overrun pins", {tx_irq, rx_irq, any_irq}, 3'b001);
    rd_check("R12 tx overrun bit", A_INT, 32'h4);
    apb_write(A_INT, 32'h4);
    apb_write(A_STAT, 32'h4);
    apb_write(A_CTRL, 32'h1);
    repeat (60) @(negedge clk);
    apb_write(A_CTRL, 32'h2A);
    rx_send(8'h5E, 4);
    check("R12 rx pins", {tx_irq, rx_irq, any_irq}, 3'b011);
    rx_send(8'h5F, 4);
    rd_check("R12 rx and rx overrun bits", A_INT, 32'hA);
    apb_write(A_INT, 32'hF);
    rd_check("R13 all cleared", A_INT, 0);
    apb_write(A_STAT, 32'h8);
    apb_read(A_DATA, d);

    // R13 clear on the same edge as a new receive event
    apb_write(A_CTRL, 32'hA);
    apb_write(A_DIV, 8);
    @(negedge clk);
    s = cyc + 3;
    dly = -1;
    fork
      rx_send_at(8'h6B, 8, s);
      begin
        do @(negedge clk); while (rx_irq !== 1'b1 && cyc < s + 300);
        dly = cyc - s;
      end
    join
    check("R12 rx latch seen", (dly > 0 && dly < 300) ? 1 : 0, 1);
    apb_write(A_INT, 32'h2);
    apb_read(A_DATA, d);
    for (int off = -1; off <= 1; off++) begin
      @(negedge clk);
      s = cyc + 5;
      fork
        rx_send_at(8'h6B, 8, s);
        apb_write_at(A_INT, 32'h2, s + dly + off);
      join
      check($sformatf("R13 clear offset %0d", off), rx_irq, (off <= 0) ? 1 : 0);
      apb_write(A_INT, 32'h2);
      apb_read(A_DATA, d);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule